// File: doc/BRIEF.md
# MII Management PHY Register Responder

This block stands in for the management side of an Ethernet PHY. A host strobes in a command word and an address word. The address word carries a 5-bit PHY address and a 5-bit register number. Nothing is clocked serially. A read-status command is answered one cycle later from a hard-wired register set. That set describes a PHY that is linked, has finished autonegotiation and runs at 100 Mb/s full duplex.

The answer lands in a receive-data output and holds until the next read-status command. A read aimed at any PHY address other than the configured one returns all ones. The same happens for a register number the set does not define. Write-data and scan-status commands are accepted but change nothing, so the link always reads as up. The configured PHY address is a parameter. Only its low 5 bits are used.

Top module: `mii_mgmt_responder`

## Requirements
- R1: After reset `rx_data_o` is 0x0000 and `busy_o` is 0.
- R2: A command counts only when `cmd_we_i` is high and `cmd_i` is exactly one of 3'b001 (scan-status), 3'b010 (read-status) or 3'b100 (write-data). Any other value, or a low strobe, leaves both outputs unchanged from idle.
- R3: `busy_o` is high for exactly the one cycle after the edge that captures a counted command, and low otherwise.
- R4: On a read-status command, `rx_data_o` takes its new value at the capturing clock edge. The PHY field is `addr_i[4:0]` and the register field is `addr_i[9:5]`.
- R5: When the PHY field differs from the configured address, `rx_data_o` becomes 0xFFFF.
- R6: Register 2 reads 0x0022 and register 3 reads 0x1613.
- R7: Register 0 reads 0x0100, register 1 reads 0x7824, register 4 reads 0x0141 and register 5 reads 0x03C0.
- R8: Register 25 reads the configured PHY address, zero-extended.
- R9: Registers 6, 9, 10, 15, 18 to 24 and 26 to 28 read 0x0000. Every other register number reads 0xFFFF.
- R10: Write-data and scan-status commands leave `rx_data_o` unchanged.
- R11: The configured PHY address is masked to 5 bits, both when it is compared with the PHY field and when it is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 3 | Command word, one-hot |
| addr_i | input | 10 | Register number [9:5], PHY address [4:0] |
| rx_data_o | output | 16 | Receive-data value |
| busy_o | output | 1 | High for one cycle after a counted command |

## Verification
A new command can arrive in the same cycle in which `busy_o` reports the previous one. Whether a read-status response lands can also depend on the same edge that captures the following command. The bench provokes both by issuing strobes back to back with no gap, mixing reads, writes, scans and invalid codes. In every cycle it compares both outputs with a model that steps one edge at a time. Each response must appear exactly one edge after its own strobe, and `busy_o` must stay high across consecutive counted commands.

// File: rtl/mii_resp_pkg.sv
package mii_resp_pkg;
  localparam int PHY_AW  = 5;
  localparam int REG_AW  = 5;
  localparam int ADDR_W  = PHY_AW + REG_AW;
  localparam int DATA_W  = 16;
  localparam int CMD_W   = 3;
  localparam int NUM_REG = 1 << REG_AW;

  localparam int SCAN_BIT  = 0;
  localparam int READ_BIT  = 1;
  localparam int WRITE_BIT = 2;

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  typedef struct packed {
    logic valid;
    logic read;
  } cmd_dec_t;

  // canned contents of a linked 100M full-duplex PHY
  function automatic logic [DATA_W-1:0] reg_value(logic [REG_AW-1:0] ra,
                                                  logic [PHY_AW-1:0] own);
    logic [DATA_W-1:0] v;
    case (ra)
      5'd0:  v = 16'h0100;
      5'd1:  v = 16'h7824;
      5'd2:  v = 16'h0022;
      5'd3:  v = 16'h1613;
      5'd4:  v = 16'h0141;
      5'd5:  v = 16'h03C0;
      5'd6, 5'd9, 5'd10, 5'd15,
      5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23, 5'd24,
      5'd26, 5'd27, 5'd28: v = '0;
      5'd25: v = {{(DATA_W-PHY_AW){1'b0}}, own};
      default: v = ALL_ONES;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/mii_cmd_decode.sv
module mii_cmd_decode
  import mii_resp_pkg::*;
(
  input  logic             we_i,
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_dec_t         dec_o
);
  localparam logic [CMD_W-1:0] C_SCAN  = CMD_W'(1) << SCAN_BIT;
  localparam logic [CMD_W-1:0] C_READ  = CMD_W'(1) << READ_BIT;
  localparam logic [CMD_W-1:0] C_WRITE = CMD_W'(1) << WRITE_BIT;

  always_comb begin
    dec_o.valid = we_i && (cmd_i == C_SCAN || cmd_i == C_READ || cmd_i == C_WRITE);
    dec_o.read  = we_i && (cmd_i == C_READ);
  end
endmodule

// File: rtl/mii_phy_table.sv
module mii_phy_table
  import mii_resp_pkg::*;
#(
  parameter logic [PHY_AW-1:0] OWN_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] table_q [NUM_REG];
  logic [PHY_AW-1:0] phy_f;
  logic [REG_AW-1:0] reg_f;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_tbl
    assign table_q[g] = reg_value(REG_AW'(g), OWN_ADDR);
  end

  assign phy_f  = addr_i[PHY_AW-1:0];
  assign reg_f  = addr_i[ADDR_W-1:PHY_AW];
  assign data_o = (phy_f == OWN_ADDR) ? table_q[reg_f] : ALL_ONES;
endmodule

// File: rtl/mii_rd_reg.sv
module mii_rd_reg
  import mii_resp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_dec_t          dec_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      busy_o    <= 1'b0;
    end else begin
      busy_o <= dec_i.valid;
      if (dec_i.read) rx_data_o <= data_i;
    end
  end
endmodule

// File: rtl/mii_mgmt_responder.sv
module mii_mgmt_responder
  import mii_resp_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o
);
  localparam logic [PHY_AW-1:0] OWN_ADDR = PHY_AW'(PHY_ADDR);

  cmd_dec_t          dec;
  logic [DATA_W-1:0] tbl_data;

  mii_cmd_decode u_dec (
    .we_i  (cmd_we_i),
    .cmd_i (cmd_i),
    .dec_o (dec)
  );

  mii_phy_table #(.OWN_ADDR(OWN_ADDR)) u_tbl (
    .addr_i (addr_i),
    .data_o (tbl_data)
  );

  mii_rd_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (dec),
    .data_i    (tbl_data),
    .rx_data_o (rx_data_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/mii_mgmt_responder_chk.sv
module mii_mgmt_responder_chk
  import mii_resp_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              busy_o
);
  localparam logic [PHY_AW-1:0] OWN = PHY_AW'(PHY_ADDR);

  logic cmd_ok, rd_cmd;
  assign cmd_ok = cmd_we_i && (cmd_i == 3'b001 || cmd_i == 3'b010 || cmd_i == 3'b100);
  assign rd_cmd = cmd_we_i && (cmd_i == 3'b010);

  p_busy_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ok |=> busy_o);

  p_busy_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ok |=> !busy_o);

  p_mismatch_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && addr_i[PHY_AW-1:0] != OWN) |=> rx_data_o == 16'hFFFF);

  p_hold_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cmd |=> $stable(rx_data_o));

  p_id1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && addr_i == {5'd2, OWN}) |=> rx_data_o == 16'h0022);

  p_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && addr_i == {5'd1, OWN}) |=> rx_data_o == 16'h7824);
endmodule

bind mii_mgmt_responder mii_mgmt_responder_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (.*);

// File: tb/mii_mgmt_responder_tb_top.sv
`timescale 1ns/1ps
module mii_mgmt_responder_tb_top;
  localparam int CFG_ADDR = 'h27;            // masks to 7
  localparam logic [4:0] OWN = 5'd7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [9:0]  addr_i = '0;
  logic [15:0] rx_data_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_rx = 16'h0000;
  logic        exp_busy = 1'b0;

  always #10 clk_i = ~clk_i;

  mii_mgmt_responder #(.PHY_ADDR(CFG_ADDR)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
    .addr_i(addr_i), .rx_data_o(rx_data_o), .busy_o(busy_o)
  );

  function automatic logic [15:0] model(logic [4:0] phy, logic [4:0] ra);
    if (phy != OWN) return 16'hFFFF;
    if (ra == 0) return 16'h0100;
    if (ra == 1) return 16'h7824;
    if (ra == 2) return 16'h0022;
    if (ra == 3) return 16'h1613;
    if (ra == 4) return 16'h0141;
    if (ra == 5) return 16'h03C0;
    if (ra == 25) return {11'd0, OWN};
    if (ra == 6 || ra == 9 || ra == 10 || ra == 15) return 16'h0000;
    if (ra >= 18 && ra <= 28) return 16'h0000;
    return 16'hFFFF;
  endfunction

  task automatic check(string tag);
    checks += 2;
    if (rx_data_o !== exp_rx) begin
      errors++;
      $display("FAIL %s rx_data act=%h exp=%h", tag, rx_data_o, exp_rx);
    end
    if (busy_o !== exp_busy) begin
      errors++;
      $display("FAIL %s busy act=%b exp=%b", tag, busy_o, exp_busy);
    end
  endtask

  // drive after a negedge, check at the following negedge
  task automatic step(logic we, logic [2:0] c, logic [4:0] ra, logic [4:0] phy, string tag);
    cmd_we_i = we; cmd_i = c; addr_i = {ra, phy};
    exp_busy = we && (c == 3'b001 || c == 3'b010 || c == 3'b100);
    if (we && c == 3'b010) exp_rx = model(phy, ra);
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset");

    // full table, matching PHY (R6 R7 R8 R9 R11)
    for (int r = 0; r < 32; r++) begin
      step(1'b1, 3'b010, 5'(r), OWN, "R4 R6 R7 R8 R9 R11 table read");
    end
    step(1'b0, 3'b000, 5'd0, OWN, "R3 idle after burst");

    // mismatch, including the unmasked upper bits of the config (R5 R11)
    step(1'b1, 3'b010, 5'd2, 5'd0, "R5 mismatch");
    step(1'b1, 3'b010, 5'd3, 5'h17, "R5 R11 mismatch near");
    step(1'b1, 3'b010, 5'd25, OWN, "R8 R11 phy readback");

    // write and scan keep data (R10)
    step(1'b1, 3'b100, 5'd1, OWN, "R10 write");
    step(1'b1, 3'b001, 5'd0, 5'd3, "R10 scan");
    step(1'b0, 3'b000, 5'd0, 5'd0, "R10 idle");

    // invalid codes and low strobe (R2)
    step(1'b1, 3'b000, 5'd2, OWN, "R2 zero code");
    step(1'b1, 3'b011, 5'd2, OWN, "R2 two-hot");
    step(1'b1, 3'b110, 5'd2, OWN, "R2 two-hot");
    step(1'b1, 3'b111, 5'd2, OWN, "R2 all bits");
    step(1'b0, 3'b010, 5'd3, OWN, "R2 strobe low");

    // back-to-back mixes (R3 R4)
    step(1'b1, 3'b010, 5'd0, OWN, "R3 R4 b2b");
    step(1'b1, 3'b100, 5'd2, OWN, "R3 R10 b2b");
    step(1'b1, 3'b010, 5'd3, OWN, "R3 R4 b2b");
    step(1'b1, 3'b010, 5'd7, OWN, "R3 R9 b2b");
    step(1'b1, 3'b101, 5'd1, OWN, "R2 R3 b2b");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] c;
      logic [4:0] ph;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1, 2, 3: c = 3'b010;
        4: c = 3'b100;
        5: c = 3'b001;
        default: c = 3'($urandom_range(0, 7));
      endcase
      ph = ($urandom_range(0, 3) != 0) ? OWN : 5'($urandom_range(0, 31));
      step(($urandom_range(0, 4) != 0), c, 5'($urandom_range(0, 31)), ph, "R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule